// File: doc/BRIEF.md
# Conversion Queue Scan Sequencer

This block runs the lower-priority queue of an analog conversion scheduler. It holds a 16-bit control word that sets the queue's start index, its operating mode, its interrupt enables, its one-shot arm bit and its resume policy. Once armed, it walks a 64-entry command table in ascending order. For each entry it issues one conversion to an external converter over a start/done handshake. The scan ends at an entry carrying an end marker, or after the last table slot.

A higher-priority queue can suspend the scan at any time by holding a suspend input. Any conversion in flight is then abandoned. On release, the scan resumes either at the abandoned entry or at the head of the current sub-queue, as the resume policy selects. A sub-queue begins at the queue's first entry or just after an entry that carries the pause flag. The start index also tells the other queue where its own region of the table stops. Two sticky interrupt requests, one for scan completion and one for pause-flagged entries, stay raised until each is acknowledged.

Top module: `qscan_seq`

## Requirements
- R1: The control word holds the completion interrupt enable at bit 15, the pause interrupt enable at bit 14, the one-shot arm at bit 13, the 5-bit mode at bits 12:8, the resume select at bit 7 and the 7-bit start index at bits 6:0. A read returns the stored fields with bit 13 always 0. After reset the word reads 0x0040.
- R2: The output `q1_end` always equals the stored start index.
- R3: Mode 1 starts a scan as soon as the arm bit is set. Mode 2 starts a scan on a `trig` pulse while the arm bit is set. Mode 0 and every other code never start a scan.
- R4: A scan issues conversions for indices start, start+1, and so on, one per entry. It ends after the entry whose end marker is set, or after index 63. A start index of 64 or more ends the scan at once with no conversion.
- R5: The hardware clears the arm bit when a scan ends, so no further scan starts until software arms it again.
- R6: If the completion enable is set when a scan ends, `irq_cmpl` rises and stays high until an `ack_cmpl` pulse.
- R7: If the pause enable is set when the conversion of a pause-flagged entry completes, `irq_pause` rises and stays high until an `ack_pause` pulse.
- R8: A trigger that arrives while a scan is active is ignored.
- R9: While `hold` is high no conversion starts, and a conversion in flight is abandoned. After release, resume select 1 restarts at the abandoned entry. Resume select 0 restarts at the first entry of the current sub-queue, which is the start index or the entry after the latest pause-flagged entry.
- R10: A resume select written during a scan takes effect only at the end of that scan, or when the same write changes the mode.
- R11: Writing a mode other than 1 or 2 during a scan stops it at once. No completion interrupt is raised and the arm bit is cleared.
- R12: `conv_start` is a one-cycle pulse. The next pulse comes only after `conv_done` for the previous conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read data (arm bit reads 0) |
| q1_end | output | 7 | End of the higher-priority queue's region (start index) |
| trig | input | 1 | External trigger pulse for mode 2 |
| hold | input | 1 | Suspend request from the higher-priority queue |
| tbl_idx | output | 6 | Command table read index |
| tbl_pause | input | 1 | Pause flag of the entry at `tbl_idx` |
| tbl_eoq | input | 1 | End marker of the entry at `tbl_idx` |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_done | input | 1 | Conversion finished pulse |
| irq_cmpl | output | 1 | Sticky completion interrupt request |
| irq_pause | output | 1 | Sticky pause interrupt request |
| ack_cmpl | input | 1 | Clears `irq_cmpl` |
| ack_pause | input | 1 | Clears `irq_pause` |

## Verification
The bench suspends scans in mid-conversion under both resume policies and with a pause-flagged entry in front. A design that mixed up the resume point would repeat the wrong entries or skip an entry. It changes the resume select during a scan, once with the mode unchanged and once together with a mode change, to catch a design that honours the new policy too early or never. It also covers an empty queue, a scan that runs off index 63, a trigger during a scan, re-triggering after the arm bit should have cleared, and switching the mode off mid-scan. Those cases expose a wrapped index, a lost completion, a repeated scan or a late conversion.

// File: rtl/qscan_pkg.sv
package qscan_pkg;
    localparam int unsigned TBL_DEPTH = 64;
    localparam int unsigned IDX_W     = $clog2(TBL_DEPTH);
    localparam int unsigned BQ_W      = IDX_W + 1;
    localparam int unsigned MODE_W    = 5;
    localparam int unsigned CW_W      = 3 + MODE_W + 1 + BQ_W;

    // bit positions inside the control word (MSB side holds the enables)
    localparam int unsigned POS_CIE  = CW_W - 1;
    localparam int unsigned POS_PIE  = CW_W - 2;
    localparam int unsigned POS_ARM  = CW_W - 3;
    localparam int unsigned POS_MODE = CW_W - 4;
    localparam int unsigned POS_RSEL = BQ_W;

    localparam logic [MODE_W-1:0] MODE_OFF = MODE_W'(0);
    localparam logic [MODE_W-1:0] MODE_SW  = MODE_W'(1);
    localparam logic [MODE_W-1:0] MODE_EXT = MODE_W'(2);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WAIT,
        ST_SUSP
    } scan_st_e;

    typedef struct packed {
        logic              cie;
        logic              pie;
        logic [MODE_W-1:0] mode;
        logic              rsel;
        logic [BQ_W-1:0]   bq;
    } qcfg_t;

    function automatic logic mode_runs(input logic [MODE_W-1:0] m);
        return (m == MODE_SW) || (m == MODE_EXT);
    endfunction
endpackage

// File: rtl/qscan_cfg.sv
module qscan_cfg
    import qscan_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CW_W-1:0] wr_data,
    input  logic            clr_arm,
    output qcfg_t           cfg,
    output logic            arm,
    output logic            mode_upd,
    output logic [CW_W-1:0] rd_data
);
    typedef struct packed {
        qcfg_t cfg;
        logic  arm;
        logic  upd;
    } cfg_reg_t;

    cfg_reg_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.upd = 1'b0;
        if (clr_arm) begin
            r_d.arm = 1'b0;
        end
        if (wr_en) begin
            r_d.cfg.cie  = wr_data[POS_CIE];
            r_d.cfg.pie  = wr_data[POS_PIE];
            r_d.arm      = wr_data[POS_ARM];
            r_d.cfg.mode = wr_data[POS_MODE -: MODE_W];
            r_d.cfg.rsel = wr_data[POS_RSEL];
            r_d.cfg.bq   = wr_data[BQ_W-1:0];
            r_d.upd      = (wr_data[POS_MODE -: MODE_W] != r_q.cfg.mode);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{cfg: '{cie: 1'b0, pie: 1'b0, mode: MODE_OFF, rsel: 1'b0,
                            bq: BQ_W'(TBL_DEPTH)},
                     arm: 1'b0, upd: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg      = r_q.cfg;
    assign arm      = r_q.arm;
    assign mode_upd = r_q.upd;
    assign rd_data  = {r_q.cfg.cie, r_q.cfg.pie, 1'b0, r_q.cfg.mode,
                       r_q.cfg.rsel, r_q.cfg.bq};

    AST_ARM_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_arm && !wr_en) |=> !arm); // R5
endmodule

// File: rtl/qscan_irq.sv
module qscan_irq #(
    parameter int unsigned N_REQ = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] set,
    input  logic [N_REQ-1:0] ack,
    output logic [N_REQ-1:0] req
);
    logic [N_REQ-1:0] req_d, req_q;

    always_comb begin
        for (int i = 0; i < N_REQ; i++) begin
            // a new event wins over an acknowledge in the same cycle
            req_d[i] = set[i] | (req_q[i] & ~ack[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req = req_q;

    for (genvar g = 0; g < N_REQ; g++) begin : g_chk
        AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (req_q[g] && !ack[g]) |=> req_q[g]); // R6
        AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[g] && !set[g]) |=> !req_q[g]); // R7
    end
endmodule

// File: rtl/qscan_ctrl.sv
module qscan_ctrl
    import qscan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  qcfg_t            cfg,
    input  logic             arm,
    input  logic             mode_upd,
    input  logic             trig,
    input  logic             hold,
    input  logic             ent_pause,
    input  logic             ent_eoq,
    input  logic             conv_done,
    output logic [IDX_W-1:0] ent_idx,
    output logic             conv_start,
    output logic             scan_end,
    output logic             set_cmpl,
    output logic             set_pause
);
    typedef struct packed {
        scan_st_e         st;
        logic [IDX_W-1:0] idx;   // entry being issued or in flight
        logic [IDX_W-1:0] sub;   // head of the current sub-queue
        logic             pf;    // pause flag of the entry in flight
        logic             ef;    // end marker of the entry in flight
        logic             rs;    // resume select in force
    } ctl_t;

    ctl_t c_d, c_q;
    logic             last;
    logic             go;
    logic             abort;
    logic [IDX_W-1:0] resume_at;

    always_comb begin
        c_d        = c_q;
        conv_start = 1'b0;
        scan_end   = 1'b0;
        set_cmpl   = 1'b0;
        set_pause  = 1'b0;
        last       = c_q.ef || (c_q.idx == IDX_W'(TBL_DEPTH - 1));
        resume_at  = c_q.rs ? c_q.idx : c_q.sub;
        go         = arm && ((cfg.mode == MODE_SW) || ((cfg.mode == MODE_EXT) && trig));
        abort      = mode_upd && !mode_runs(cfg.mode) && (c_q.st != ST_IDLE);

        // policy follows the register only while idle or on a mode change
        if ((c_q.st == ST_IDLE) || mode_upd) begin
            c_d.rs = cfg.rsel;
        end

        unique case (c_q.st)
            ST_IDLE: begin
                if (go) begin
                    if (cfg.bq[BQ_W-1]) begin
                        scan_end = 1'b1;
                        set_cmpl = cfg.cie;
                    end else begin
                        c_d.st  = ST_RUN;
                        c_d.idx = cfg.bq[IDX_W-1:0];
                        c_d.sub = cfg.bq[IDX_W-1:0];
                    end
                end
            end
            ST_RUN: begin
                if (hold) begin
                    c_d.st  = ST_SUSP;
                    c_d.idx = resume_at;
                end else begin
                    conv_start = 1'b1;
                    c_d.pf     = ent_pause;
                    c_d.ef     = ent_eoq;
                    c_d.st     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (conv_done) begin
                    set_pause = c_q.pf && cfg.pie;
                    if (last) begin
                        c_d.st   = ST_IDLE;
                        scan_end = 1'b1;
                        set_cmpl = cfg.cie;
                        c_d.rs   = cfg.rsel;
                    end else begin
                        c_d.idx = c_q.idx + 1'b1;
                        if (c_q.pf) begin
                            c_d.sub = c_q.idx + 1'b1;
                        end
                        c_d.st = ST_RUN;
                    end
                end else if (hold) begin
                    c_d.st  = ST_SUSP;
                    c_d.idx = resume_at;
                end
            end
            ST_SUSP: begin
                if (!hold) begin
                    c_d.st = ST_RUN;
                end
            end
        endcase

        if (abort) begin
            c_d.st     = ST_IDLE;
            conv_start = 1'b0;
            scan_end   = 1'b1;
            set_cmpl   = 1'b0;
            set_pause  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, idx: '0, sub: '0, pf: 1'b0, ef: 1'b0, rs: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign ent_idx = c_q.idx;

    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R12
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_WAIT) && conv_done && !last && !abort)
            |=> (ent_idx == $past(ent_idx) + 1'b1)); // R4
    AST_HOLD_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_WAIT) && hold && !conv_done && !abort)
            |=> (c_q.st == ST_SUSP)); // R9
endmodule

// File: rtl/qscan_seq.sv
module qscan_seq
    import qscan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CW_W-1:0]  cfg_wdata,
    output logic [CW_W-1:0]  cfg_rdata,
    output logic [BQ_W-1:0]  q1_end,
    input  logic             trig,
    input  logic             hold,
    output logic [IDX_W-1:0] tbl_idx,
    input  logic             tbl_pause,
    input  logic             tbl_eoq,
    output logic             conv_start,
    input  logic             conv_done,
    output logic             irq_cmpl,
    output logic             irq_pause,
    input  logic             ack_cmpl,
    input  logic             ack_pause
);
    qcfg_t      cfg;
    logic       arm;
    logic       mode_upd;
    logic       scan_end;
    logic       set_cmpl;
    logic       set_pause;
    logic [1:0] irq_req;

    qscan_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_data  (cfg_wdata),
        .clr_arm  (scan_end),
        .cfg      (cfg),
        .arm      (arm),
        .mode_upd (mode_upd),
        .rd_data  (cfg_rdata)
    );

    qscan_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .arm        (arm),
        .mode_upd   (mode_upd),
        .trig       (trig),
        .hold       (hold),
        .ent_pause  (tbl_pause),
        .ent_eoq    (tbl_eoq),
        .conv_done  (conv_done),
        .ent_idx    (tbl_idx),
        .conv_start (conv_start),
        .scan_end   (scan_end),
        .set_cmpl   (set_cmpl),
        .set_pause  (set_pause)
    );

    qscan_irq #(.N_REQ(2)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   ({set_pause, set_cmpl}),
        .ack   ({ack_pause, ack_cmpl}),
        .req   (irq_req)
    );

    assign irq_cmpl  = irq_req[0];
    assign irq_pause = irq_req[1];
    assign q1_end    = cfg.bq;
endmodule

// File: tb/sim_qscan_seq.sv
`timescale 1ns/1ps
module sim_qscan_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [6:0]  q1_end;
    logic        trig = 1'b0;
    logic        hold = 1'b0;
    logic [5:0]  tbl_idx;
    logic        tbl_pause, tbl_eoq;
    logic        conv_start;
    logic        conv_done;
    logic        irq_cmpl, irq_pause;
    logic        ack_cmpl = 1'b0;
    logic        ack_pause = 1'b0;

    int n_run = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    qscan_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .q1_end(q1_end), .trig(trig), .hold(hold),
        .tbl_idx(tbl_idx), .tbl_pause(tbl_pause), .tbl_eoq(tbl_eoq),
        .conv_start(conv_start), .conv_done(conv_done),
        .irq_cmpl(irq_cmpl), .irq_pause(irq_pause),
        .ack_cmpl(ack_cmpl), .ack_pause(ack_pause)
    );

    // command table model
    logic pause_tbl [64];
    logic eoq_tbl   [64];
    assign tbl_pause = pause_tbl[tbl_idx];
    assign tbl_eoq   = eoq_tbl[tbl_idx];

    // converter model: fixed latency, a held suspend cancels the job
    int   lat = 3;
    int   cnt = 0;
    logic pend = 1'b0;
    logic cdone = 1'b0;
    assign conv_done = cdone;

    // log of issued indices
    int   lg [32];
    int   ln = 0;
    logic lclr = 1'b0;

    always @(posedge clk) begin
        cdone <= 1'b0;
        if (!rst_n || hold) begin
            pend <= 1'b0;
        end else if (conv_start) begin
            pend <= 1'b1;
            cnt  <= lat;
        end else if (pend) begin
            if (cnt <= 1) begin
                pend  <= 1'b0;
                cdone <= 1'b1;
            end else begin
                cnt <= cnt - 1;
            end
        end
        if (lclr) begin
            ln <= 0;
        end else if (rst_n && conv_start && ln < 32) begin
            lg[ln] <= int'(tbl_idx);
            ln     <= ln + 1;
        end
    end

    // register write / readback vectors: write data, read data, q1_end
    localparam int NV = 6;
    localparam logic [15:0] VW [NV] = '{16'hFFFF, 16'h0040, 16'h8000, 16'h2000, 16'h1F7F, 16'h4080};
    localparam logic [15:0] VR [NV] = '{16'hDFFF, 16'h0040, 16'h8000, 16'h0000, 16'h1F7F, 16'h4080};
    localparam logic [6:0]  VQ [NV] = '{7'h7F,    7'h40,    7'h00,    7'h00,    7'h7F,    7'h00};

    task automatic chk(input string tag, input logic ok, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [15:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_tbl();
        for (int i = 0; i < 64; i++) begin
            pause_tbl[i] = 1'b0;
            eoq_tbl[i]   = 1'b0;
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        lclr = 1'b1;
        @(negedge clk);
        lclr = 1'b0;
    endtask

    task automatic wait_cnt(input int k);
        for (int g = 0; g < 500 && ln < k; g++) @(negedge clk);
    endtask

    task automatic pulse_ack(input logic which_pause);
        @(negedge clk);
        if (which_pause) ack_pause = 1'b1; else ack_cmpl = 1'b1;
        @(negedge clk);
        ack_pause = 1'b0;
        ack_cmpl  = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic hold_for(input int n);
        hold = 1'b1;
        tick(n);
        hold = 1'b0;
    endtask

    task automatic chk_seq(input string tag, input int exp [10], input int len);
        chk({tag, " count"}, ln == len, ln, len);
        for (int i = 0; i < len && i < ln; i++) begin
            chk({tag, " index"}, lg[i] == exp[i], lg[i], exp[i]);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin : main
        clear_tbl();
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // reset state
        chk("R1 reset word", cfg_rdata == 16'h0040, cfg_rdata, 16'h0040);
        chk("R2 reset q1_end", q1_end == 7'd64, q1_end, 64);
        chk("R6 reset irq_cmpl", irq_cmpl == 1'b0, irq_cmpl, 0);
        chk("R7 reset irq_pause", irq_pause == 1'b0, irq_pause, 0);
        chk("R12 reset conv_start", conv_start == 1'b0, conv_start, 0);

        // R1/R2 vector walk (no vector arms a running mode)
        for (int i = 0; i < NV; i++) begin
            cfg_write(VW[i]);
            chk("R1 readback", cfg_rdata == VR[i], cfg_rdata, VR[i]);
            chk("R2 q1_end", q1_end == VQ[i], q1_end, VQ[i]);
        end
        chk("R3 mode 31 starts nothing", ln == 0, ln, 0);
        cfg_write(16'h0040);
        clear_log();

        // R3/R4/R6/R7: software scan 10..13, pause at 11
        clear_tbl();
        pause_tbl[11] = 1'b1;
        eoq_tbl[13]   = 1'b1;
        cfg_write(16'hE10A);
        tick(60);
        chk_seq("R4 sw scan", '{10, 11, 12, 13, 0, 0, 0, 0, 0, 0}, 4);
        chk("R6 cmpl raised", irq_cmpl == 1'b1, irq_cmpl, 1);
        chk("R7 pause raised", irq_pause == 1'b1, irq_pause, 1);
        chk("R1 arm reads zero", cfg_rdata == 16'hC10A, cfg_rdata, 16'hC10A);
        tick(30);
        chk("R5 no rescan", ln == 4, ln, 4);

        // R6/R7 acknowledges are independent
        pulse_ack(1'b0);
        chk("R6 ack clears cmpl", irq_cmpl == 1'b0, irq_cmpl, 0);
        chk("R7 pause kept", irq_pause == 1'b1, irq_pause, 1);
        tick(5);
        chk("R6 cmpl stays low", irq_cmpl == 1'b0, irq_cmpl, 0);
        pulse_ack(1'b1);
        chk("R7 ack clears pause", irq_pause == 1'b0, irq_pause, 0);

        // R3/R5: external trigger scan 20..21
        clear_tbl();
        eoq_tbl[21] = 1'b1;
        clear_log();
        cfg_write(16'h2214);
        tick(20);
        chk("R3 waits for trigger", ln == 0, ln, 0);
        pulse_trig();
        tick(40);
        chk_seq("R3 ext scan", '{20, 21, 0, 0, 0, 0, 0, 0, 0, 0}, 2);
        pulse_trig();
        tick(30);
        chk("R5 disarmed after scan", ln == 2, ln, 2);

        // R8: trigger during an active scan
        clear_tbl();
        eoq_tbl[32] = 1'b1;
        lat = 8;
        clear_log();
        cfg_write(16'h221E);
        pulse_trig();
        wait_cnt(1);
        pulse_trig();
        tick(80);
        chk_seq("R8 retrigger ignored", '{30, 31, 32, 0, 0, 0, 0, 0, 0, 0}, 3);
        lat = 3;

        // R4/R6: empty queue completes at once
        clear_tbl();
        clear_log();
        cfg_write(16'hA140);
        tick(10);
        chk("R4 empty no conversion", ln == 0, ln, 0);
        chk("R6 empty cmpl", irq_cmpl == 1'b1, irq_cmpl, 1);
        pulse_ack(1'b0);

        // R4: run off the top of the table
        clear_log();
        cfg_write(16'h213D);
        tick(60);
        chk_seq("R4 stop at 63", '{61, 62, 63, 0, 0, 0, 0, 0, 0, 0}, 3);

        // R9: suspend, resume at aborted entry
        clear_tbl();
        eoq_tbl[44] = 1'b1;
        lat = 6;
        clear_log();
        cfg_write(16'h21A8);
        wait_cnt(3);
        hold_for(5);
        tick(80);
        chk_seq("R9 resume aborted", '{40, 41, 42, 42, 43, 44, 0, 0, 0, 0}, 6);

        // R9: suspend, restart at sub-queue head after pause entry 41
        clear_tbl();
        pause_tbl[41] = 1'b1;
        eoq_tbl[45]   = 1'b1;
        clear_log();
        cfg_write(16'h2128);
        wait_cnt(4);
        hold_for(5);
        tick(100);
        chk_seq("R9 resume sub-queue", '{40, 41, 42, 43, 42, 43, 44, 45, 0, 0}, 8);

        // R10: select change mid-scan without mode change is deferred
        clear_tbl();
        eoq_tbl[44] = 1'b1;
        clear_log();
        cfg_write(16'h21A8);
        wait_cnt(2);
        cfg_write(16'h0128);
        wait_cnt(3);
        hold_for(5);
        tick(80);
        chk_seq("R10 deferred select", '{40, 41, 42, 42, 43, 44, 0, 0, 0, 0}, 6);

        // R10: select change together with a mode change applies at once
        clear_log();
        cfg_write(16'h21A8);
        wait_cnt(2);
        cfg_write(16'h0228);
        wait_cnt(3);
        hold_for(5);
        tick(100);
        chk_seq("R10 mode change select", '{40, 41, 42, 40, 41, 42, 43, 44, 0, 0}, 8);
        lat = 3;

        // R11: mode off mid-scan
        clear_tbl();
        eoq_tbl[10] = 1'b1;
        lat = 6;
        clear_log();
        cfg_write(16'hA100);
        wait_cnt(2);
        cfg_write(16'h8000);
        tick(60);
        chk("R11 scan stopped", ln == 2, ln, 2);
        chk("R11 no completion", irq_cmpl == 1'b0, irq_cmpl, 0);
        lat = 3;

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule